// File: doc/BRIEF.md
# Pad Interrupt Capture and Masking Unit

This block turns activity on a wide set of already-synchronised pad inputs into a single interrupt request. Each pad carries a two-bit trigger mode and a flag saying whether its interrupt routing field is non-zero. A pad that qualifies records an event in a sticky status bit. Status bits are grouped into 32-bit words, each with a matching 32-bit enable word, and the request line is raised whenever any status bit meets a set enable bit.

Software reaches the status and enable words over a simple 32-bit register port with byte addresses. Status words are cleared by writing ones. Enable words are plain read/write masks. The pad configuration store and the input synchronisers are outside this block and feed it directly.

Top module: `gpio_irq_unit`

## Requirements
- R1: After reset every status word and every enable word reads 0 and `irq_o` is low.
- R2: A pad with mode 0 (level) and its select flag set raises its status bit on every cycle in which its input is high.
- R3: A pad with mode 1 (rising edge) and its select flag set raises its status bit only when its input is high in a cycle and was low in the cycle before; an input held high after the bit is cleared does not set it again.
- R4: Mode values 2 and 3 capture nothing: the status bit stays 0 whatever the input does.
- R5: A pad whose select flag is 0 never sets its status bit, in any mode.
- R6: Status word i sits at byte address 0x14 + 4*i; a write there clears each status bit whose data bit is 1 and leaves bits written with 0 unchanged.
- R7: Enable word i sits at byte address 0x24 + 4*i and reads back what was last written; in both word kinds, bit j of word i belongs to pad 32*i + j (pad mode occupies `pad_mode[2p+1:2p]`).
- R8: A status bit latches whether or not its enable bit is set.
- R9: `irq_o` is high in the cycle after some status bit and its enable bit are both 1, and low in the cycle after no such pair exists.
- R10: When an event and a clearing write hit the same status bit in the same cycle, the bit ends up set.
- R11: A read with `rd_en` returns its data on `rd_data` with `rd_valid` high one cycle later; addresses outside the two word groups read 0 and writes to them change nothing.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| pad_in | input | 128 | Synchronised pad levels |
| pad_mode | input | 256 | Per-pad trigger mode, two bits per pad |
| pad_sel_nz | input | 128 | Per-pad flag: routing select field is non-zero |
| wr_en | input | 1 | Register write strobe |
| rd_en | input | 1 | Register read strobe |
| addr | input | 8 | Byte address |
| wr_data | input | 32 | Write data |
| rd_data | output | 32 | Read data |
| rd_valid | output | 1 | Read data valid, one cycle after `rd_en` |
| irq_o | output | 1 | Combined interrupt request |

## Verification
The bench clears a level-mode bit while its input is still high and expects it to stay set; a design that let the clear win would drop a live event and read 0. It clears an edge-mode bit with the input held high and expects no re-trigger; a design that treated edge like level would read the bit back as 1. It masks and unmasks a latched bit and checks the request one cycle late each time, which catches an unregistered or wrongly qualified output, and it writes zeros and out-of-range addresses to show that nothing else moves.

// File: rtl/gpio_irq_pkg.sv
package gpio_irq_pkg;

    typedef enum logic [1:0] {
        TRIG_LEVEL = 2'd0,
        TRIG_RISE  = 2'd1,
        TRIG_OFF   = 2'd2,
        TRIG_RSVD  = 2'd3
    } trig_mode_e;

    localparam int unsigned WORD_BYTES = 4;

endpackage

// File: rtl/gpio_irq_detect.sv
module gpio_irq_detect
    import gpio_irq_pkg::*;
#(
    parameter int unsigned N_PADS = 128
) (
    input  logic                  clk,
    input  logic                  rst_n,
    input  logic [N_PADS-1:0]     pad_in,
    input  logic [2*N_PADS-1:0]   pad_mode,
    input  logic [N_PADS-1:0]     pad_sel_nz,
    output logic [N_PADS-1:0]     event_o
);

    typedef struct packed {
        logic [N_PADS-1:0] prev;
    } det_state_t;

    det_state_t st_d, st_q;

    always_comb begin
        st_d      = st_q;
        st_d.prev = pad_in;
    end

    for (genvar p = 0; p < N_PADS; p++) begin : g_pad
        trig_mode_e mode;
        always_comb begin
            mode = trig_mode_e'(pad_mode[2*p +: 2]);
            case (mode)
                TRIG_LEVEL: event_o[p] = pad_sel_nz[p] & pad_in[p];
                TRIG_RISE:  event_o[p] = pad_sel_nz[p] & pad_in[p] & ~st_q.prev[p];
                default:    event_o[p] = 1'b0;
            endcase
        end

        AST_OFF_NO_EVENT: assert property (@(posedge clk) disable iff (!rst_n)
            (pad_mode[2*p+1] || !pad_sel_nz[p]) |-> !event_o[p]); // R4
    end

    // Previous levels reset high so a pad already high at reset is not seen as rising.
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q.prev <= '1;
        end else begin
            st_q <= st_d;
        end
    end

endmodule

// File: rtl/gpio_irq_bank.sv
module gpio_irq_bank #(
    parameter int unsigned BANK_W = 32
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [BANK_W-1:0] event_i,
    input  logic              sts_wr,
    input  logic              en_wr,
    input  logic [BANK_W-1:0] wr_data,
    output logic [BANK_W-1:0] sts_o,
    output logic [BANK_W-1:0] en_o,
    output logic [BANK_W-1:0] pend_o
);

    typedef struct packed {
        logic [BANK_W-1:0] sts;
        logic [BANK_W-1:0] en;
    } bank_state_t;

    bank_state_t st_d, st_q;
    logic [BANK_W-1:0] clr_mask;

    always_comb begin
        st_d     = st_q;
        clr_mask = sts_wr ? wr_data : '0;
        // Events are ORed in after the clear, so a coincident set survives.
        st_d.sts = (st_q.sts & ~clr_mask) | event_i;
        if (en_wr) begin
            st_d.en = wr_data;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign sts_o  = st_q.sts;
    assign en_o   = st_q.en;
    assign pend_o = st_q.sts & st_q.en;

    AST_SET_WINS: assert property (@(posedge clk) disable iff (!rst_n)
        (event_i != '0) |=> ((st_q.sts & $past(event_i)) == $past(event_i))); // R10

    AST_W1C_CLEARS: assert property (@(posedge clk) disable iff (!rst_n)
        sts_wr |=> ((st_q.sts & $past(wr_data & ~event_i)) == '0)); // R6

    AST_STS_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
        !sts_wr |=> (($past(st_q.sts) & ~st_q.sts) == '0)); // R6

    AST_EN_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        !en_wr |=> $stable(st_q.en)); // R7

endmodule

// File: rtl/gpio_irq_unit.sv
module gpio_irq_unit
    import gpio_irq_pkg::*;
#(
    parameter int unsigned N_PADS   = 128,
    parameter int unsigned BANK_W   = 32,
    parameter int unsigned ADDR_W   = 8,
    parameter int unsigned STS_BASE = 32'h14,
    parameter int unsigned EN_BASE  = 32'h24
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic [127:0]        pad_in,
    input  logic [255:0]        pad_mode,
    input  logic [127:0]        pad_sel_nz,
    input  logic                wr_en,
    input  logic                rd_en,
    input  logic [7:0]          addr,
    input  logic [31:0]         wr_data,
    output logic [31:0]         rd_data,
    output logic                rd_valid,
    output logic                irq_o
);

    localparam int unsigned N_BANKS = N_PADS / BANK_W;
    localparam int unsigned IDX_W   = (N_BANKS > 1) ? $clog2(N_BANKS) : 1;
    localparam int unsigned SPAN    = N_BANKS * WORD_BYTES;

    typedef struct packed {
        logic              irq;
        logic              rvalid;
        logic [BANK_W-1:0] rdata;
    } top_state_t;

    top_state_t st_d, st_q;

    logic [N_PADS-1:0] events;
    logic [BANK_W-1:0] sts_w  [N_BANKS];
    logic [BANK_W-1:0] en_w   [N_BANKS];
    logic [BANK_W-1:0] pend_w [N_BANKS];
    logic              sts_hit, en_hit;
    logic [IDX_W-1:0]  word_idx;
    logic              any_pend;

    gpio_irq_detect #(.N_PADS(N_PADS)) u_detect (
        .clk        (clk),
        .rst_n      (rst_n),
        .pad_in     (pad_in),
        .pad_mode   (pad_mode),
        .pad_sel_nz (pad_sel_nz),
        .event_o    (events)
    );

    always_comb begin
        int unsigned a;
        a        = 32'(addr);
        sts_hit  = (a >= STS_BASE) && (a < STS_BASE + SPAN) && (addr[1:0] == 2'b00);
        en_hit   = (a >= EN_BASE)  && (a < EN_BASE  + SPAN) && (addr[1:0] == 2'b00);
        word_idx = '0;
        if (sts_hit) begin
            word_idx = IDX_W'((a - STS_BASE) / WORD_BYTES);
        end else if (en_hit) begin
            word_idx = IDX_W'((a - EN_BASE) / WORD_BYTES);
        end
    end

    for (genvar b = 0; b < N_BANKS; b++) begin : g_bank
        gpio_irq_bank #(.BANK_W(BANK_W)) u_bank (
            .clk     (clk),
            .rst_n   (rst_n),
            .event_i (events[b*BANK_W +: BANK_W]),
            .sts_wr  (wr_en && sts_hit && (word_idx == IDX_W'(b))),
            .en_wr   (wr_en && en_hit  && (word_idx == IDX_W'(b))),
            .wr_data (wr_data),
            .sts_o   (sts_w[b]),
            .en_o    (en_w[b]),
            .pend_o  (pend_w[b])
        );
    end

    always_comb begin
        any_pend = 1'b0;
        for (int b = 0; b < N_BANKS; b++) begin
            any_pend = any_pend | (|pend_w[b]);
        end
    end

    always_comb begin
        st_d        = st_q;
        st_d.irq    = any_pend;
        st_d.rvalid = rd_en;
        if (rd_en) begin
            st_d.rdata = '0;
            if (sts_hit) begin
                st_d.rdata = sts_w[word_idx];
            end else if (en_hit) begin
                st_d.rdata = en_w[word_idx];
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign irq_o    = st_q.irq;
    assign rd_valid = st_q.rvalid;
    assign rd_data  = st_q.rdata;

    AST_IRQ_RISES: assert property (@(posedge clk) disable iff (!rst_n)
        any_pend |=> irq_o); // R9

    AST_IRQ_FALLS: assert property (@(posedge clk) disable iff (!rst_n)
        !any_pend |=> !irq_o); // R9

    AST_RD_VALID: assert property (@(posedge clk) disable iff (!rst_n)
        rd_en |=> rd_valid); // R11

    AST_BAD_ADDR_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_en && !sts_hit && !en_hit) |=> (rd_data == '0)); // R11

endmodule

// File: tb/tb_gpio_irq_unit.sv
module tb_gpio_irq_unit;

    logic         clk = 1'b0;
    logic         rst_n = 1'b0;
    logic [127:0] pad_in = '0;
    logic [255:0] pad_mode = {128{2'b10}};
    logic [127:0] pad_sel_nz = '1;
    logic         wr_en = 1'b0;
    logic         rd_en = 1'b0;
    logic [7:0]   addr = '0;
    logic [31:0]  wr_data = '0;
    logic [31:0]  rd_data;
    logic         rd_valid;
    logic         irq_o;

    int total = 0;
    int bad = 0;
    bit done = 1'b0;

    typedef struct {
        logic [31:0] exp;
        string       tag;
    } sb_item_t;

    sb_item_t sb_q[$];

    always #5 clk = ~clk;

    gpio_irq_unit dut (
        .clk        (clk),
        .rst_n      (rst_n),
        .pad_in     (pad_in),
        .pad_mode   (pad_mode),
        .pad_sel_nz (pad_sel_nz),
        .wr_en      (wr_en),
        .rd_en      (rd_en),
        .addr       (addr),
        .wr_data    (wr_data),
        .rd_data    (rd_data),
        .rd_valid   (rd_valid),
        .irq_o      (irq_o)
    );

    // Monitor: pops the expected item for each returned read.
    initial begin
        forever begin
            @(negedge clk);
            if (rd_valid) begin
                sb_item_t it;
                total++;
                if (sb_q.size() == 0) begin
                    bad++;
                    $display("FAIL %s: unexpected read data %h, expected none", "R11", rd_data);
                end else begin
                    it = sb_q.pop_front();
                    if (rd_data !== it.exp) begin
                        bad++;
                        $display("FAIL %s: read %h, expected %h", it.tag, rd_data, it.exp);
                    end
                end
            end
        end
    end

    task automatic tick(int n = 1);
        repeat (n) @(negedge clk);
    endtask

    task automatic reg_wr(logic [7:0] a, logic [31:0] d);
        addr = a; wr_data = d; wr_en = 1'b1;
        tick();
        wr_en = 1'b0;
    endtask

    task automatic reg_rd(logic [7:0] a, logic [31:0] exp, string tag);
        sb_item_t it;
        it.exp = exp; it.tag = tag;
        sb_q.push_back(it);
        addr = a; rd_en = 1'b1;
        tick();
        rd_en = 1'b0;
    endtask

    task automatic chk_irq(logic exp, string tag);
        total++;
        if (irq_o !== exp) begin
            bad++;
            $display("FAIL %s: irq_o=%b, expected %b", tag, irq_o, exp);
        end
    endtask

    task automatic set_mode(int p, logic [1:0] m);
        pad_mode[2*p +: 2] = m;
    endtask

    initial begin
        tick(3);
        rst_n = 1'b1;
        tick();

        // R1: reset state
        chk_irq(1'b0, "R1");
        reg_rd(8'h14, 32'h0, "R1 sts0");
        reg_rd(8'h20, 32'h0, "R1 sts3");
        reg_rd(8'h28, 32'h0, "R1 en1");

        // R2: level mode on pad 5
        set_mode(5, 2'd0);
        pad_in[5] = 1'b1;
        tick(2);
        pad_in[5] = 1'b0;
        tick();
        reg_rd(8'h14, 32'h20, "R2 level set");
        reg_wr(8'h14, 32'h20);
        reg_rd(8'h14, 32'h0, "R6 clear by one");
        // R10: clear while level input still high
        pad_in[5] = 1'b1;
        tick();
        reg_wr(8'h14, 32'h20);
        reg_rd(8'h14, 32'h20, "R10 set wins");
        pad_in[5] = 1'b0;
        tick();
        reg_wr(8'h14, 32'hFFFF_FFFF);
        reg_rd(8'h14, 32'h0, "R2 cleared after low");

        // R3: rising edge on pad 40 (word 1 bit 8)
        set_mode(40, 2'd1);
        pad_in[40] = 1'b1;
        tick(2);
        reg_rd(8'h18, 32'h100, "R3 edge set");
        reg_wr(8'h18, 32'h100);
        tick(2);
        reg_rd(8'h18, 32'h0, "R3 held high no retrigger");
        pad_in[40] = 1'b0;
        tick();
        pad_in[40] = 1'b1;
        tick();
        reg_rd(8'h18, 32'h100, "R3 second edge");
        reg_wr(8'h18, 32'h100);
        pad_in[40] = 1'b0;

        // R4: modes 2 and 3 capture nothing
        set_mode(70, 2'd2);
        set_mode(71, 2'd3);
        pad_in[70] = 1'b1; pad_in[71] = 1'b1;
        tick(3);
        reg_rd(8'h1C, 32'h0, "R4 disabled modes");
        pad_in[70] = 1'b0; pad_in[71] = 1'b0;

        // R5: select flag zero
        set_mode(100, 2'd0);
        pad_sel_nz[100] = 1'b0;
        pad_in[100] = 1'b1;
        tick(3);
        reg_rd(8'h20, 32'h0, "R5 select zero");
        pad_in[100] = 1'b0;

        // R8: latch with enable off, pad 127 (word 3 bit 31)
        set_mode(127, 2'd0);
        pad_in[127] = 1'b1;
        tick();
        pad_in[127] = 1'b0;
        tick(2);
        reg_rd(8'h20, 32'h8000_0000, "R8 latched while masked");
        chk_irq(1'b0, "R8 masked no irq");

        // R9: unmask, one-cycle delay
        reg_wr(8'h30, 32'h8000_0000);
        chk_irq(1'b0, "R9 not yet");
        tick();
        chk_irq(1'b1, "R9 asserted");
        reg_rd(8'h30, 32'h8000_0000, "R7 enable readback");
        reg_wr(8'h30, 32'h0);
        chk_irq(1'b1, "R9 mask delay");
        tick();
        chk_irq(1'b0, "R9 masked");
        reg_wr(8'h30, 32'h8000_0000);
        tick();
        chk_irq(1'b1, "R9 re-enabled");
        // R6: zero write leaves bit set
        reg_wr(8'h20, 32'h0);
        reg_rd(8'h20, 32'h8000_0000, "R6 zero write keeps");
        reg_wr(8'h20, 32'h8000_0000);
        chk_irq(1'b1, "R9 clear delay");
        tick();
        chk_irq(1'b0, "R9 cleared");

        // R7: enable word mapping
        reg_wr(8'h24, 32'hA5A5_0F0F);
        reg_rd(8'h24, 32'hA5A5_0F0F, "R7 en0");
        reg_rd(8'h2C, 32'h0, "R7 en2 untouched");

        // R11: unmapped addresses
        reg_wr(8'h34, 32'hFFFF_FFFF);
        reg_wr(8'h10, 32'hFFFF_FFFF);
        reg_rd(8'h34, 32'h0, "R11 read past enables");
        reg_rd(8'h10, 32'h0, "R11 read below status");
        reg_rd(8'h2C, 32'h0, "R11 write ignored");
        reg_rd(8'h15, 32'h0, "R11 misaligned");

        tick(3);
        done = 1'b1;
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            total++;
            bad++;
            $display("FAIL watchdog: run hung, actual=running expected=finished");
            $display("test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

endmodule